// File: doc/BRIEF.md
# Four-Lane Horizontal Reduce and Field Split Unit

This unit serves pixel-channel work in a datapath. It takes four 32-bit elements and applies one of three operations. Two operations fold the four elements into a single word: one adds them and one multiplies them. The third takes one source word and cuts it into four equal bit fields. Each field is moved down to bit 0 of its own output lane, and the bits above the field are cleared. With 8-bit fields this splits a packed four-channel pixel into separate channel values. Adding four channel words whose set bits do not overlap gives the same result as ORing them, so the add operation also packs channels back together.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream. A beat is accepted on any rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on any rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its error flag stay frozen. The internal pipeline has two stages, so at most two operations can be in flight. `in_ready` goes low only when both stages hold data and the output is stalled.

Each operation has an error case. A split request is rejected when its field width is zero, or when four fields of that width would need more than 32 bits. The reserved opcode is also rejected. A rejected operation produces a result with the error flag set and all data lanes zero.

Top module: `quad_reduce_split`

## Requirements
- R1: Opcode 0 (sum) gives out_data lane 0 = (in_elems[0]+in_elems[1]+in_elems[2]+in_elems[3]) mod 2^32. Lanes 1..3 are zero and out_err is 0.
- R2: Opcode 1 (product) gives out_data lane 0 = the low 32 bits of the product of all four elements. Lanes 1..3 are zero and out_err is 0.
- R3: For four elements with pairwise disjoint set bits, the sum result equals their bitwise OR.
- R4: Opcode 2 (split) with field width w taken from in_width, where 1 <= w <= 8, gives lane i = (in_elems[0] >> (i*w)) & (2^w - 1) for i = 0..3, and out_err is 0.
- R5: A split with w = 8 returns byte i of in_elems[0] (bits 8i+7..8i) in lane i.
- R6: A split with w = 0, or with 4*w > 32, returns out_err = 1 and all lanes zero.
- R7: Opcode 3 is reserved and returns out_err = 1 with all lanes zero. The sum and product opcodes ignore in_width, including width 0.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_err remain unchanged on the next cycle.
- R9: With an empty pipeline and out_ready high, a beat accepted at rising edge k makes out_valid rise after edge k+1. Results leave in the order they were accepted. in_ready is low exactly when both stages are full and out_ready is low.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept a beat |
| in_op | input | 2 | 0 sum, 1 product, 2 split, 3 reserved |
| in_width | input | 6 | Field width in bits for split |
| in_elems | input | 128 | Four 32-bit elements, element i at bits 32i+31..32i; split uses element 0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four 32-bit result lanes, lane i at bits 32i+31..32i |
| out_err | output | 1 | Operation rejected |

## Verification
The assertions assume the consumer never needs a result to change while it holds `out_ready` low. They also assume that every accepted beat carries a defined opcode, so that the lane-clearing checks have a known operation to test against. The stimulus drives inputs only at falling edges and sets all operand fields together with `in_valid`. Opcodes and widths are drawn from their full encodings, widths up to 11, so rejected splits and the reserved opcode appear mixed among legal operations. Random output stalls of up to two cycles keep the hold rule under constant exercise. A directed burst with the output blocked fills both stages to test back-pressure.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int unsigned NLANE = 4;

  typedef enum logic [1:0] {
    QOP_SUM   = 2'd0,
    QOP_PROD  = 2'd1,
    QOP_SPLIT = 2'd2,
    QOP_RSVD  = 2'd3
  } qop_e;
endpackage

// File: rtl/qrs_add_tree.sv
module qrs_add_tree #(
  parameter int unsigned DW = 32
) (
  input  logic [3:0][DW-1:0] elems,
  output logic [DW-1:0]      total
);
  logic [1:0][DW-1:0] pair_sum;

  // first level: two independent adders
  for (genvar j = 0; j < 2; j++) begin : g_lvl1
    assign pair_sum[j] = elems[2*j] + elems[2*j+1];
  end

  // second level closes the tree; carry out of bit DW-1 is dropped
  assign total = pair_sum[0] + pair_sum[1];
endmodule

// File: rtl/qrs_mul_pair.sv
module qrs_mul_pair #(
  parameter int unsigned DW = 32
) (
  input  logic [3:0][DW-1:0] elems,
  output logic [1:0][DW-1:0] partial
);
  // only the low DW bits of each factor affect the low DW bits of the final product
  for (genvar j = 0; j < 2; j++) begin : g_pair
    assign partial[j] = elems[2*j] * elems[2*j+1];
  end
endmodule

// File: rtl/qrs_field_split.sv
module qrs_field_split #(
  parameter int unsigned DW = 32,
  parameter int unsigned WW = 6
) (
  input  logic [DW-1:0]      src,
  input  logic [WW-1:0]      width,
  output logic [3:0][DW-1:0] lanes,
  output logic               bad_width
);
  localparam int unsigned SW = WW + 2;

  logic [SW-1:0] wide_w;
  logic [DW-1:0] field_mask;

  assign wide_w    = {2'b00, width};
  assign bad_width = (width == '0) || ((wide_w << 2) > SW'(DW));
  assign field_mask = bad_width ? '0 : ({DW{1'b1}} >> (SW'(DW) - wide_w));

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [SW-1:0] shamt;
    assign shamt    = SW'(i) * wide_w;
    assign lanes[i] = bad_width ? '0 : ((src >> shamt) & field_mask);
  end
endmodule

// File: rtl/quad_reduce_split.sv
module quad_reduce_split
  import qrs_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned WW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_op,
  input  logic [WW-1:0]       in_width,
  input  logic [3:0][DW-1:0]  in_elems,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [3:0][DW-1:0]  out_data,
  output logic                out_err
);
  // ---------------- stage 1 datapath ----------------
  logic [DW-1:0]      tree_sum;
  logic [1:0][DW-1:0] prod_part;
  logic [3:0][DW-1:0] split_lanes;
  logic               split_bad;

  qrs_add_tree #(.DW(DW)) u_tree (
    .elems (in_elems),
    .total (tree_sum)
  );

  qrs_mul_pair #(.DW(DW)) u_mul (
    .elems   (in_elems),
    .partial (prod_part)
  );

  qrs_field_split #(.DW(DW), .WW(WW)) u_split (
    .src       (in_elems[0]),
    .width     (in_width),
    .lanes     (split_lanes),
    .bad_width (split_bad)
  );

  qop_e               op_in;
  logic [3:0][DW-1:0] s1_next;
  logic               s1_err_next;

  assign op_in = qop_e'(in_op);

  always_comb begin
    s1_next     = '0;
    s1_err_next = 1'b0;
    unique case (op_in)
      QOP_SUM:   s1_next[0] = tree_sum;
      QOP_PROD:  begin
        s1_next[0] = prod_part[0];
        s1_next[1] = prod_part[1];
      end
      QOP_SPLIT: begin
        s1_next     = split_lanes;
        s1_err_next = split_bad;
      end
      default:   s1_err_next = 1'b1;
    endcase
  end

  // ---------------- pipeline control ----------------
  logic               s1_valid;
  qop_e               s1_op;
  logic               s1_err;
  logic [3:0][DW-1:0] s1_data;
  qop_e               out_op;
  logic               s2_adv;
  logic               in_fire;

  assign s2_adv   = !out_valid || out_ready;
  assign in_ready = !s1_valid || s2_adv;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_op   <= op_in;
      s1_err  <= s1_err_next;
      s1_data <= s1_next;
    end
  end

  // ---------------- stage 2: closing multiply ----------------
  logic [3:0][DW-1:0] s2_next;

  always_comb begin
    s2_next = s1_data;
    if (s1_op == QOP_PROD) begin
      s2_next    = '0;
      s2_next[0] = s1_data[0] * s1_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (s2_adv) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_adv && s1_valid) begin
      out_data <= s2_next;
      out_err  <= s1_err;
      out_op   <= s1_op;
    end
  end

  // ---------------- checks ----------------
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

  // R1
  reduce_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == QOP_SUM || out_op == QOP_PROD))
      |-> (!out_err && out_data[1] == '0 && out_data[2] == '0 && out_data[3] == '0));

  // R9
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> s1_valid);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_adv) |=> out_valid);
endmodule

// File: tb/tb_quad_reduce_split.sv
`timescale 1ns/1ps
module tb_quad_reduce_split;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_op = '0;
  logic [5:0]        in_width = '0;
  logic [3:0][31:0]  in_elems = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [3:0][31:0]  out_data;
  logic              out_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  quad_reduce_split dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_width(in_width), .in_elems(in_elems),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sum(input logic [3:0][31:0] e);
    longint s = 0;
    for (int i = 0; i < 4; i++) s += longint'(e[i]);
    return s[31:0];
  endfunction

  function automatic logic [31:0] ref_prod(input logic [3:0][31:0] e);
    logic [31:0] p = 32'd1;
    for (int i = 0; i < 4; i++) begin
      longint unsigned t;
      t = longint'(p) * longint'(e[i]);
      p = t[31:0];
    end
    return p;
  endfunction

  function automatic logic [128:0] ref_result(input logic [1:0] op, input logic [5:0] w,
                                              input logic [3:0][31:0] e);
    logic [3:0][31:0] d = '0;
    logic err = 1'b0;
    case (op)
      2'd0: d[0] = ref_sum(e);
      2'd1: d[0] = ref_prod(e);
      2'd2: begin
        if (w == 0 || int'(w) * 4 > 32) err = 1'b1;
        else
          for (int i = 0; i < 4; i++)
            for (int b = 0; b < int'(w); b++)
              d[i][b] = e[0][i*int'(w) + b];
      end
      default: err = 1'b1;
    endcase
    return {err, d};
  endfunction

  task automatic run_one(input logic [1:0] op, input logic [5:0] w, input logic [3:0][31:0] e,
                         input int stall, input string tag);
    logic [128:0] exp;
    exp = ref_result(op, w, e);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_width = w; in_elems = e;
    out_ready = (stall == 0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, {tag, " R9 latency early"}, 128'(out_valid), 128'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, {tag, " R9 latency"}, 128'(out_valid), 128'd1);
    chk(out_data == exp[127:0], {tag, " data"}, out_data, exp[127:0]);
    chk(out_err == exp[128], {tag, " err"}, 128'(out_err), 128'(exp[128]));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_data == exp[127:0] && out_err == exp[128],
          {tag, " R8 hold"}, out_data, exp[127:0]);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, {tag, " R9 drained"}, 128'(out_valid), 128'd0);
  endtask

  function automatic logic [3:0][31:0] pk(input logic [31:0] a, b, c, d);
    logic [3:0][31:0] r;
    r[0] = a; r[1] = b; r[2] = c; r[3] = d;
    return r;
  endfunction

  initial begin
    logic [3:0][31:0] ea, eb, ec;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 128'(in_ready), 128'd1);
    chk(out_valid == 1'b0, "R10 out_valid after reset", 128'(out_valid), 128'd0);

    run_one(2'd0, 6'd0, pk(1, 2, 3, 4), 0, "R1 small sum");
    run_one(2'd0, 6'd5, pk(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF), 1, "R1 wrap sum");
    run_one(2'd1, 6'd0, pk(2, 3, 5, 7), 0, "R2 small product");
    run_one(2'd1, 6'd9, pk(32'h12345678, 32'h9ABCDEF1, 32'hFFFFFFFF, 32'h10001), 2, "R2 wrap product");
    run_one(2'd0, 6'd8, pk(32'h11, 32'h2200, 32'h330000, 32'h44000000), 0, "R3 disjoint sum equals OR");
    run_one(2'd2, 6'd8, pk(32'hAABBCCDD, 0, 0, 0), 0, "R5 byte split");
    run_one(2'd2, 6'd3, pk(32'hDEADBEEF, 32'h5, 0, 0), 1, "R4 width 3");
    run_one(2'd2, 6'd1, pk(32'h0000000A, 0, 0, 0), 0, "R4 width 1");
    run_one(2'd2, 6'd7, pk(32'hFFFFFFFF, 0, 0, 0), 0, "R4 width 7");
    run_one(2'd2, 6'd0, pk(32'hFFFFFFFF, 0, 0, 0), 0, "R6 width 0");
    run_one(2'd2, 6'd9, pk(32'hFFFFFFFF, 0, 0, 0), 1, "R6 width 9");
    run_one(2'd2, 6'd63, pk(32'hFFFFFFFF, 0, 0, 0), 0, "R6 width 63");
    run_one(2'd3, 6'd8, pk(1, 2, 3, 4), 0, "R7 reserved op");
    run_one(2'd1, 6'd0, pk(3, 3, 3, 3), 0, "R7 product ignores width");

    // R9 back-pressure burst
    ea = pk(1, 1, 1, 1); eb = pk(2, 2, 2, 2); ec = pk(3, 3, 3, 3);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 2'd0; in_width = 6'd0; in_elems = ea;
    @(negedge clk);
    in_elems = eb;
    @(negedge clk);
    in_elems = ec;
    chk(in_ready == 1'b0, "R9 in_ready low when full", 128'(in_ready), 128'd0);
    chk(out_valid && out_data[0] == 32'd4, "R9 first result", out_data, 128'd4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data[0] == 32'd8, "R9 order second", out_data, 128'd8);
    @(negedge clk);
    chk(out_valid && out_data[0] == 32'd12, "R9 order third", out_data, 128'd12);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 burst drained", 128'(out_valid), 128'd0);

    // random mix covering R1 R2 R4 R6 R7 R8
    for (int n = 0; n < 300; n++) begin
      logic [3:0][31:0] er;
      logic [1:0] op;
      logic [5:0] w;
      for (int i = 0; i < 4; i++) er[i] = $urandom;
      op = 2'($urandom % 4);
      w  = 6'($urandom % 12);
      run_one(op, w, er, int'($urandom % 3), "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule